// File: doc/BRIEF.md
# Running Absolute Maximum Search Unit

This unit is the datapath behind one search instruction. In a single operation it does three jobs. It takes the magnitude of a signed 32-bit candidate. It compares that magnitude with the best magnitude found so far. If the candidate is larger, it stores the magnitude and the current loop counter together. A loop that scores candidates one per cycle can drive the candidate and the loop counter straight into the unit. When the loop ends, the largest magnitude and the position where it first appeared are waiting in two registers.

A clear input starts a fresh search. It resets the stored magnitude and the stored index to zero. The candidate input is qualified by a valid strobe, so idle cycles inside the loop leave the result alone. Both outputs come from registers. A winning candidate appears on the outputs one cycle after it is accepted.

Top module: `amax_search_unit`

## Requirements
- R1: With `rst_n` low at a rising clock edge, both `best_mag` and `best_idx` become zero on that edge, whatever the other inputs are (synchronous, active-low reset).
- R2: The magnitude of `cand` is its two's-complement absolute value. It is compared with `best_mag` as an unsigned 32-bit number over all 32 bits.
- R3: The magnitude saturates. A candidate of 0x80000000 gives a magnitude of 0x7FFFFFFF.
- R4: When a candidate wins, `best_idx` takes the value of `loop_idx` on the same edge that `best_mag` takes the magnitude.
- R5: `clr` high at an edge sets both outputs to zero. It takes priority over a valid candidate in the same cycle, and that candidate is dropped.
- R6: An update happens only when the magnitude is strictly greater than `best_mag`. On a tie, both registers keep their values, so the earliest index of the maximum is kept.
- R7: With `cand_vld` low and `clr` low, both outputs hold their values, whatever `cand` and `loop_idx` carry.
- R8: The outputs change only at a clock edge. A candidate accepted at one edge is visible from that edge until the next one. No input reaches the outputs without passing through a clock edge.
- R9: `best_mag` never exceeds 0x7FFFFFFF, so its top bit is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Start a new search: zero both results |
| cand_vld | input | 1 | Qualifies `cand` and `loop_idx` for this cycle |
| cand | input | 32 | Signed two's-complement candidate |
| loop_idx | input | 8 | Current loop counter value |
| best_mag | output | 32 | Largest magnitude seen since the last clear |
| best_idx | output | 8 | Loop counter value at which `best_mag` was first reached |

## Verification
The hardest cases to reach are the ones where a candidate must not win even though it looks like it could. These include a negative candidate whose magnitude only ties the current best, and the most negative input whose saturated magnitude ties a stored 0x7FFFFFFF. Directed sequences first build a known best value. They then send exactly these tie candidates with new loop indices and check that the index does not move. A separate sequence sends a clear and a large valid candidate in the same cycle to show that the clear wins. The register timing is checked by sampling the outputs right after the inputs change and before the edge.

// File: rtl/amax_pkg.sv
// Shared types for the running absolute maximum search unit.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package amax_pkg;

    // Action chosen for the result registers in one cycle.
    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_TAKE  = 2'd1,
        ACT_CLEAR = 2'd2
    } amax_act_e;

endpackage

// File: rtl/amax_abs.sv
// Magnitude of a signed two's-complement word.
// SATURATE=1 maps the most negative code to the largest positive code.
// SATURATE=0 returns the plain wrapped negation.
// Purely combinational; assumes W >= 2.
module amax_abs #(
    parameter int W        = 32,
    parameter bit SATURATE = 1'b1
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    logic          is_neg;
    logic [W-1:0]  negated;
    logic          is_min;

    // Sign, negation and most-negative detection.
    always_comb begin
        is_neg  = val[W-1];
        negated = ~val + {{(W-1){1'b0}}, 1'b1};
        is_min  = is_neg && (val[W-2:0] == '0);
    end

    generate
        if (SATURATE) begin : g_sat
            // Saturating magnitude.
            always_comb begin
                if (!is_neg)     mag = val;
                else if (is_min) mag = MAX_POS;
                else             mag = negated;
            end
        end else begin : g_wrap
            // Wrapping magnitude.
            always_comb begin
                mag = is_neg ? negated : val;
            end
        end
    endgenerate

endmodule

// File: rtl/amax_decide.sv
// Picks the register action for one cycle.
// A clear beats everything.
// A valid candidate is taken only when strictly greater, compared unsigned.
// Purely combinational.
module amax_decide
    import amax_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clr,
    input  logic          vld,
    input  logic [W-1:0]  cand_mag,
    input  logic [W-1:0]  best_mag,
    output amax_act_e     act
);
    logic wins;

    // Full-width strict comparison and priority selection.
    always_comb begin
        wins = cand_mag > best_mag;
        if (clr)              act = ACT_CLEAR;
        else if (vld && wins) act = ACT_TAKE;
        else                  act = ACT_KEEP;
    end

endmodule

// File: rtl/amax_store.sv
// Result registers: the best magnitude and its index are loaded together.
// Synchronous active-low reset.
module amax_store
    import amax_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  amax_act_e     act,
    input  logic [W-1:0]  new_mag,
    input  logic [IW-1:0] new_idx,
    output logic [W-1:0]  mag_q,
    output logic [IW-1:0] idx_q
);
    // Reset, clear, or capture both values in one step.
    always_ff @(posedge clk) begin
        if (!rst_n || act == ACT_CLEAR) begin
            mag_q <= '0;
            idx_q <= '0;
        end else if (act == ACT_TAKE) begin
            mag_q <= new_mag;
            idx_q <= new_idx;
        end
    end

endmodule

// File: rtl/amax_search_unit.sv
// Running absolute maximum search unit.
// Per accepted candidate it does the absolute value, the 32-bit compare,
// and a joint update of the magnitude and index registers.
// Assumes one candidate per cycle at most; loop control lives outside.
module amax_search_unit
    import amax_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cand_vld,
    input  logic [DATA_W-1:0] cand,
    input  logic [IDX_W-1:0]  loop_idx,
    output logic [DATA_W-1:0] best_mag,
    output logic [IDX_W-1:0]  best_idx
);
    logic [DATA_W-1:0] cand_mag;
    amax_act_e         act;

    amax_abs #(.W(DATA_W), .SATURATE(1'b1)) u_abs (
        .val (cand),
        .mag (cand_mag)
    );

    amax_decide #(.W(DATA_W)) u_decide (
        .clr      (clr),
        .vld      (cand_vld),
        .cand_mag (cand_mag),
        .best_mag (best_mag),
        .act      (act)
    );

    amax_store #(.W(DATA_W), .IW(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .new_mag (cand_mag),
        .new_idx (loop_idx),
        .mag_q   (best_mag),
        .idx_q   (best_idx)
    );

endmodule

// File: rtl/amax_search_unit_chk.sv
// Property checker for amax_search_unit, attached by bind.
// It computes the candidate magnitude on its own.
module amax_search_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              cand_vld,
    input logic [DATA_W-1:0] cand,
    input logic [IDX_W-1:0]  loop_idx,
    input logic [DATA_W-1:0] best_mag,
    input logic [IDX_W-1:0]  best_idx
);
    localparam logic [DATA_W-1:0] TOP = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] ref_mag;

    // Reference magnitude, written as a saturating abs of the signed value.
    always_comb begin
        if ($signed(cand) >= 0)                                ref_mag = cand;
        else if (cand == {1'b1, {(DATA_W-1){1'b0}}})           ref_mag = TOP;
        else                                                   ref_mag = DATA_W'(-$signed(cand));
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (best_mag == '0 && best_idx == '0)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cand_vld) |=> ($stable(best_mag) && $stable(best_idx))); // R7

    AST_TAKE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cand_vld && ref_mag > best_mag)
            |=> (best_mag == $past(ref_mag) && best_idx == $past(loop_idx))); // R4

    AST_NO_TIE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cand_vld && ref_mag <= best_mag)
            |=> ($stable(best_mag) && $stable(best_idx))); // R6

    AST_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (best_mag >= $past(best_mag))); // R2

    AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        best_mag[DATA_W-1] == 1'b0); // R9

endmodule

bind amax_search_unit amax_search_unit_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cand_vld (cand_vld),
    .cand     (cand),
    .loop_idx (loop_idx),
    .best_mag (best_mag),
    .best_idx (best_idx)
);

// File: tb/amax_search_unit_test.sv
// Directed bench for amax_search_unit. One task per scenario.
// Inputs change on the falling edge; outputs are sampled on the next falling edge.
module amax_search_unit_test;
    localparam int DW = 32;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          cand_vld = 1'b0;
    logic [DW-1:0] cand = '0;
    logic [IW-1:0] loop_idx = '0;
    logic [DW-1:0] best_mag;
    logic [IW-1:0] best_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    amax_search_unit #(.DATA_W(DW), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cand_vld(cand_vld),
        .cand(cand), .loop_idx(loop_idx), .best_mag(best_mag), .best_idx(best_idx)
    );

    // Compare both outputs with the expected values.
    task automatic expect_out(input string req, input logic [DW-1:0] em, input logic [IW-1:0] ei);
        checks++;
        if (best_mag !== em || best_idx !== ei) begin
            fails++;
            $display("FAIL %s: actual mag=%h idx=%0d expected mag=%h idx=%0d",
                     req, best_mag, best_idx, em, ei);
        end
    endtask

    // Apply one cycle of inputs, then wait for the next falling edge.
    task automatic drive(input logic c, input logic v, input logic [DW-1:0] d, input logic [IW-1:0] i);
        clr = c; cand_vld = v; cand = d; loop_idx = i;
        @(negedge clk);
        clr = 1'b0; cand_vld = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 32'h0000_1234, 8'd7);
        drive(1'b0, 1'b1, 32'h0000_1234, 8'd7);
        expect_out("R1 reset", '0, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_positive;
        drive(1'b1, 1'b0, '0, '0);
        drive(1'b0, 1'b1, 32'd5, 8'd1);
        expect_out("R4 first", 32'd5, 8'd1);
        drive(1'b0, 1'b1, 32'd3, 8'd2);
        expect_out("R6 smaller", 32'd5, 8'd1);
        drive(1'b0, 1'b1, 32'd9, 8'd3);
        expect_out("R4 larger", 32'd9, 8'd3);
    endtask

    task automatic t_negative;
        drive(1'b0, 1'b1, -32'sd20, 8'd4);
        expect_out("R2 negative", 32'd20, 8'd4);
        drive(1'b0, 1'b1, 32'd20, 8'd5);
        expect_out("R6 tie pos", 32'd20, 8'd4);
        drive(1'b0, 1'b1, -32'sd20, 8'd6);
        expect_out("R6 tie neg", 32'd20, 8'd4);
        drive(1'b0, 1'b1, 32'hFFFF_0000, 8'd8);
        expect_out("R2 unsigned compare", 32'h0001_0000, 8'd8);
    endtask

    task automatic t_idle;
        drive(1'b0, 1'b0, 32'h7000_0000, 8'd99);
        expect_out("R7 invalid ignored", 32'h0001_0000, 8'd8);
    endtask

    task automatic t_clear;
        drive(1'b1, 1'b0, '0, 8'd3);
        expect_out("R5 clear", '0, '0);
        drive(1'b0, 1'b1, 32'd50, 8'd10);
        drive(1'b1, 1'b1, 32'h0100_0000, 8'd11);
        expect_out("R5 clear beats valid", '0, '0);
        drive(1'b0, 1'b1, 32'd0, 8'd9);
        expect_out("R6 zero vs zero", '0, '0);
    endtask

    task automatic t_saturate;
        drive(1'b0, 1'b1, 32'h8000_0000, 8'd12);
        expect_out("R3 most negative", 32'h7FFF_FFFF, 8'd12);
        expect_out("R9 top bit", {1'b0, best_mag[DW-2:0]}, 8'd12);
        drive(1'b0, 1'b1, 32'h7FFF_FFFF, 8'd13);
        expect_out("R6 tie at max", 32'h7FFF_FFFF, 8'd12);
        drive(1'b0, 1'b1, 32'h8000_0001, 8'd14);
        expect_out("R3 near min", 32'h7FFF_FFFF, 8'd12);
    endtask

    task automatic t_latency;
        drive(1'b1, 1'b0, '0, '0);
        clr = 1'b0; cand_vld = 1'b1; cand = 32'd77; loop_idx = 8'd21;
        #1;
        expect_out("R8 no comb path", '0, '0);
        @(negedge clk);
        cand_vld = 1'b0;
        expect_out("R8 one cycle", 32'd77, 8'd21);
    endtask

    task automatic t_midreset;
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 32'd500, 8'd30);
        expect_out("R1 mid-run reset", '0, '0);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_positive();
        t_negative();
        t_idle();
        t_clear();
        t_saturate();
        t_latency();
        t_midreset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule